// File: doc/BRIEF.md
# Configurable GPIO Output Stage

This block owns one general-purpose I/O port of up to eight bits. It keeps the per-bit settings that decide how each pin behaves: output data, polarity inversion, direction, output style and pad type. From these settings it works out, for each bit, the value to present to the pad and whether the pad driver is enabled. A register read port returns any setting, the live pin levels, or the pin levels captured while reset was held.

A bit in level style drives its data bit, inverted when its polarity bit is set. A bit in pulse style stays at its idle level until a 1 is written to its data bit. That write starts one active pulse of fixed length, and the length in clock cycles comes from the clock frequency and pulse-width parameters. Open-drain pads are emulated: a logic 1 turns the driver off and a logic 0 drives low. A low-power input holds every pulse at its idle level and freezes its timer.

Top module: `gpio_out_stage`

## Requirements
- R1: While `rst_n` is low at a clock edge, the direction register is set to all ones, and the data, polarity, style and pad-type registers are set to all zeros. As a result, no pin is driven after reset.
- R2: A bit whose direction bit is 1 (input) has `pad_oe` 0 and `pad_out` 0, whatever its other settings are.
- R3: A bit set as output, level style (style bit 0) and push-pull (pad-type bit 1) has `pad_oe` 1. Its `pad_out` equals the data bit XOR the polarity bit.
- R4: A bit set as output with open-drain pad type (pad-type bit 0) never has `pad_out` 1. When its logic level is 0 it drives low (`pad_oe` 1). When its logic level is 1 the driver is off (`pad_oe` 0).
- R5: For a bit in pulse style (style bit 1), a write of 1 to the data register starts an active level in the cycle after the write edge. The active level lasts exactly PULSE_NS x CLK_HZ / 1e9 cycles, which is 50 cycles by default. The active level is 1 when the polarity bit is 0 and 0 when it is 1; at other times the bit sits at the opposite (idle) level.
- R6: For a pulse-style bit, the data register reads 1 while its pulse runs and clears itself when the pulse ends. A write of 0 to that bit has no effect.
- R7: A new write of 1 during a running pulse restarts the full pulse length, with no gap.
- R8: Changing a style bit never starts a pulse. A pulse starts only from a write of 1 to the data bit.
- R9: Reading address 0 returns the live `pin_in` levels.
- R10: Address 6 returns `pin_in` as it was sampled at the last clock edge with `rst_n` low. It does not change afterwards.
- R11: While `low_power` is 1, every pulse-style bit is held at its idle level and its remaining pulse time is frozen. The pulse resumes when `low_power` returns to 0.
- R12: Addresses 1 to 5 read back data, polarity, direction, style and pad type, in that order. Address 7 reads 0. Writes to addresses 0, 6 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| low_power | input | 1 | Holds pulses idle and freezes their timers |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | WIDTH | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | WIDTH | Register read data (combinational) |
| pin_in | input | WIDTH | Pin levels seen at the pads |
| pad_out | output | WIDTH | Per-bit value driven to the pad |
| pad_oe | output | WIDTH | Per-bit pad driver enable |

## Verification
The level-style function is tested with a table of mixed patterns: direction, data, polarity and pad type differ from bit to bit. Each row therefore separates inversion from non-inversion, open-drain from push-pull, and driven from released, all in one vector. Pulses are measured by counting active samples across a window longer than a pulse, once with each polarity. This tells an exact-length pulse apart from one that is cut short, too long or inverted. Retrigger, style switching with a 1 already stored, and low-power freezing each get a count over their own window. These counts show a restart, a spurious pulse or a lost remainder.

// File: rtl/gpio_os_pkg.sv
// Package: shared register addresses and pulse-length arithmetic for the
// GPIO output stage. Assumes a 3-bit register address space.
package gpio_os_pkg;

    typedef enum logic [2:0] {
        SEL_PIN   = 3'd0,
        SEL_DATA  = 3'd1,
        SEL_POL   = 3'd2,
        SEL_DIR   = 3'd3,
        SEL_STYLE = 3'd4,
        SEL_PAD   = 3'd5,
        SEL_CAPT  = 3'd6,
        SEL_NONE  = 3'd7
    } reg_sel_e;

    // Pulse length in cycles, never below one.
    function automatic int pulse_cycles(input int clk_hz, input int width_ns);
        longint cyc;
        cyc = (longint'(clk_hz) * longint'(width_ns)) / 64'd1_000_000_000;
        return (cyc < 1) ? 1 : int'(cyc);
    endfunction

endpackage

// File: rtl/gpio_os_regs.sv
// Module: register file of the GPIO output stage. It holds the data, polarity,
// direction, style and pad-type registers and the reset-time pin capture,
// decodes writes, produces pulse triggers and muxes the readback.
// Assumes: one write per cycle; readback is combinational.
module gpio_os_regs
    import gpio_os_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    input  logic [WIDTH-1:0] pin_in,
    input  logic [WIDTH-1:0] pulse_done,
    output logic [WIDTH-1:0] data_q,
    output logic [WIDTH-1:0] pol_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] style_q,
    output logic [WIDTH-1:0] pad_q,
    output logic [WIDTH-1:0] trig,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] capt_q;
    logic             wr_data_sel;

    assign wr_data_sel = wr_en && (wr_addr == SEL_DATA);

    // Pulse trigger: a written 1 on a bit that is in pulse style.
    assign trig = wr_data_sel ? (wr_data & style_q) : '0;

    // Configuration registers with their reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q   <= '0;
            dir_q   <= '1;
            style_q <= '0;
            pad_q   <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_addr))
                SEL_POL:   pol_q   <= wr_data;
                SEL_DIR:   dir_q   <= wr_data;
                SEL_STYLE: style_q <= wr_data;
                SEL_PAD:   pad_q   <= wr_data;
                default:   ;
            endcase
        end
    end

    // Capture of pin levels on every edge while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) capt_q <= pin_in;
    end

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_data
            // Data bit: plain store in level style; set-on-1, self-clear in pulse style.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    data_q[gi] <= 1'b0;
                end else if (wr_data_sel && (!style_q[gi] || wr_data[gi])) begin
                    data_q[gi] <= wr_data[gi];
                end else if (pulse_done[gi]) begin
                    data_q[gi] <= 1'b0;
                end
            end

            a_r6_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
                (pulse_done[gi] && !trig[gi]) |=> !data_q[gi]);
        end
    endgenerate

    // Readback multiplexer.
    always_comb begin
        case (reg_sel_e'(rd_addr))
            SEL_PIN:   rd_data = pin_in;
            SEL_DATA:  rd_data = data_q;
            SEL_POL:   rd_data = pol_q;
            SEL_DIR:   rd_data = dir_q;
            SEL_STYLE: rd_data = style_q;
            SEL_PAD:   rd_data = pad_q;
            SEL_CAPT:  rd_data = capt_q;
            default:   rd_data = '0;
        endcase
    end

    a_r1_reset_values: assert property (@(posedge clk)
        !rst_n |=> (dir_q == '1 && data_q == '0 && pol_q == '0 &&
                    style_q == '0 && pad_q == '0));

    a_r10_capture_held: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(capt_q));

endmodule

// File: rtl/gpio_os_pulse.sv
// Module: per-bit pulse timers. A trigger loads the full length; the timer
// counts down to zero, freezes in low power, and is cleared when its bit
// leaves pulse style. Assumes PULSE_CYC >= 1.
module gpio_os_pulse #(
    parameter int WIDTH     = 8,
    parameter int PULSE_CYC = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             low_power,
    input  logic [WIDTH-1:0] trig,
    input  logic [WIDTH-1:0] style_q,
    output logic [WIDTH-1:0] active,
    output logic [WIDTH-1:0] done
);

    localparam int CW = $clog2(PULSE_CYC + 1);
    localparam logic [CW-1:0] FULL = CW'(PULSE_CYC);

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            logic [CW-1:0] cnt_q;

            // Down-counter holding the remaining pulse cycles.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (trig[gi]) begin
                    cnt_q <= FULL;
                end else if (!style_q[gi]) begin
                    cnt_q <= '0;
                end else if (!low_power && cnt_q != '0) begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end

            assign active[gi] = (cnt_q != '0) && !low_power;
            assign done[gi]   = (cnt_q == CW'(1)) && style_q[gi] && !low_power && !trig[gi];

            a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_q <= FULL);
            a_r7_retrigger_full: assert property (@(posedge clk) disable iff (!rst_n)
                trig[gi] |=> cnt_q == FULL);
            a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
                (low_power && !trig[gi] && style_q[gi]) |=> $stable(cnt_q));
        end
    endgenerate

endmodule

// File: rtl/gpio_os_drive.sv
// Module: combinational pad driver per bit. It picks the logic level from
// level or pulse style, applies polarity, then maps it onto push-pull or
// emulated open-drain. Undriven bits present 0 on pad_out.
module gpio_os_drive #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] data_q,
    input  logic [WIDTH-1:0] pol_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] style_q,
    input  logic [WIDTH-1:0] pad_q,
    input  logic [WIDTH-1:0] active,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            logic lvl;
            // Logic level of the bit before pad mapping.
            always_comb begin
                lvl = style_q[gi] ? (pol_q[gi] ^ active[gi]) : (pol_q[gi] ^ data_q[gi]);
            end
            // Pad mapping: push-pull drives both levels, open-drain only low.
            always_comb begin
                pad_oe[gi]  = !dir_q[gi] && (pad_q[gi] || !lvl);
                pad_out[gi] = !dir_q[gi] && pad_q[gi] && lvl;
            end
        end
    endgenerate

endmodule

// File: rtl/gpio_out_stage.sv
// Module: top of the configurable GPIO output stage. It joins the register
// file, pulse timers and pad driver. Assumes clk runs at CLK_HZ.
module gpio_out_stage
    import gpio_os_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter int CLK_HZ   = 100_000_000,
    parameter int PULSE_NS = 500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             low_power,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    output logic [WIDTH-1:0] rd_data,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);

    localparam int PULSE_CYC = pulse_cycles(CLK_HZ, PULSE_NS);

    logic [WIDTH-1:0] data_q, pol_q, dir_q, style_q, pad_q;
    logic [WIDTH-1:0] trig, active, done;

    gpio_os_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .pin_in(pin_in),
        .pulse_done(done), .data_q(data_q), .pol_q(pol_q), .dir_q(dir_q),
        .style_q(style_q), .pad_q(pad_q), .trig(trig), .rd_data(rd_data)
    );

    gpio_os_pulse #(.WIDTH(WIDTH), .PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk(clk), .rst_n(rst_n), .low_power(low_power), .trig(trig),
        .style_q(style_q), .active(active), .done(done)
    );

    gpio_os_drive #(.WIDTH(WIDTH)) u_drive (
        .data_q(data_q), .pol_q(pol_q), .dir_q(dir_q), .style_q(style_q),
        .pad_q(pad_q), .active(active), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    a_r2_input_released: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & dir_q) == '0);
    a_r4_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_q) == '0);
    a_r11_idle_in_low_power: assert property (@(posedge clk) disable iff (!rst_n)
        low_power |-> ((pad_out & style_q & pad_q & ~dir_q) == (pol_q & style_q & pad_q & ~dir_q)));

endmodule

// File: tb/gpio_out_stage_tb.sv
module gpio_out_stage_tb;

    localparam int W = 8;
    localparam int P = 50;  // 500 ns at 100 MHz

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         low_power = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [2:0]   rd_addr = '0;
    logic [W-1:0] rd_data;
    logic [W-1:0] pin_in = 8'h5A;
    logic [W-1:0] pad_out, pad_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    gpio_out_stage #(.WIDTH(W), .CLK_HZ(100_000_000), .PULSE_NS(500)) u_dut (
        .clk(clk), .rst_n(rst_n), .low_power(low_power), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // dir, data, pol, pad, expected pad_out, expected pad_oe
    localparam logic [47:0] VEC [6] = '{
        {8'h00, 8'hF0, 8'hCC, 8'hAA, 8'h28, 8'hEB},
        {8'h0F, 8'h55, 8'h00, 8'hFF, 8'h50, 8'hF0},
        {8'h00, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00},
        {8'h00, 8'hFF, 8'h0F, 8'h00, 8'h00, 8'h0F},
        {8'hFF, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'h00},
        {8'h00, 8'hA5, 8'h00, 8'hFF, 8'hA5, 8'hFF}
    };

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic count_lvl(input int n, input int b, input logic lvl, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            if (pad_out[b] === lvl) c++;
            step();
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [W-1:0] v;
        int c;
        step(); step(); step();
        rst_n = 1'b1;
        step();

        // R1: reset state
        rd(3'd3, v); chk("R1 dir", v, 8'hFF);
        rd(3'd1, v); chk("R1 data", v, 8'h00);
        rd(3'd2, v); chk("R1 pol", v, 8'h00);
        rd(3'd4, v); chk("R1 style", v, 8'h00);
        rd(3'd5, v); chk("R1 pad", v, 8'h00);
        chk("R1 oe", pad_oe, 8'h00);
        chk("R1 out", pad_out, 8'h00);

        // R9: live input; R10: capture from reset
        pin_in = 8'h3C; rd(3'd0, v); chk("R9 live", v, 8'h3C);
        pin_in = 8'hC3; rd(3'd0, v); chk("R9 live", v, 8'hC3);
        rd(3'd6, v); chk("R10 capture", v, 8'h5A);
        // R12: writes to 0, 6, 7 ignored; address 7 reads 0
        wr(3'd6, 8'hFF); wr(3'd0, 8'hFF); wr(3'd7, 8'hFF);
        rd(3'd6, v); chk("R10 capture after write", v, 8'h5A);
        rd(3'd7, v); chk("R12 addr7", v, 8'h00);
        rd(3'd0, v); chk("R12 addr0 write ignored", v, 8'hC3);
        rd(3'd3, v); chk("R12 dir unchanged", v, 8'hFF);

        // R2, R3, R4, R12: level-style table
        for (int i = 0; i < 6; i++) begin
            wr(3'd3, VEC[i][47:40]);
            wr(3'd1, VEC[i][39:32]);
            wr(3'd2, VEC[i][31:24]);
            wr(3'd5, VEC[i][23:16]);
            chk("R3/R4/R2 pad_out", pad_out, VEC[i][15:8]);
            chk("R3/R4/R2 pad_oe", pad_oe, VEC[i][7:0]);
            rd(3'd1, v); chk("R12 data readback", v, VEC[i][39:32]);
            rd(3'd5, v); chk("R12 pad readback", v, VEC[i][23:16]);
        end

        // R5: positive pulse on bit 0
        wr(3'd3, 8'h00); wr(3'd5, 8'hFF); wr(3'd2, 8'h00); wr(3'd1, 8'h00);
        wr(3'd4, 8'h01);
        chk("R5 idle", pad_out[0], 1'b0);
        wr(3'd1, 8'h01);
        rd(3'd1, v); chk("R6 data set during pulse", v[0], 1'b1);
        count_lvl(P + 3, 0, 1'b1, c); chk("R5 width high", c, P);
        rd(3'd1, v); chk("R6 self clear", v[0], 1'b0);
        // R6: write 0 during pulse is ignored
        wr(3'd1, 8'h01); wr(3'd1, 8'h00);
        rd(3'd1, v); chk("R6 write0 ignored", v[0], 1'b1);
        count_lvl(P + 3, 0, 1'b1, c); chk("R6 pulse continues", c, P - 1);

        // R5: inverted polarity pulse
        wr(3'd2, 8'h01);
        chk("R5 idle inverted", pad_out[0], 1'b1);
        wr(3'd1, 8'h01);
        count_lvl(P + 3, 0, 1'b0, c); chk("R5 width low", c, P);
        wr(3'd2, 8'h00);

        // R7: retrigger restarts full width
        wr(3'd1, 8'h01);
        count_lvl(20, 0, 1'b1, c); chk("R7 first part", c, 20);
        wr(3'd1, 8'h01);
        count_lvl(P + 3, 0, 1'b1, c); chk("R7 restarted width", c, P);

        // R8: style change with stored 1 emits no pulse
        wr(3'd1, 8'h02);
        chk("R8 level before", pad_out[1], 1'b1);
        wr(3'd4, 8'h03);
        count_lvl(P + 10, 1, 1'b1, c); chk("R8 no pulse on switch", c, 0);
        wr(3'd4, 8'h01);
        chk("R8 level after", pad_out[1], 1'b1);
        wr(3'd1, 8'h00);

        // R11: low power freezes and idles a pulse
        wr(3'd1, 8'h01);
        count_lvl(5, 0, 1'b1, c); chk("R11 before", c, 5);
        low_power = 1'b1; #1;
        chk("R11 idle now", pad_out[0], 1'b0);
        count_lvl(30, 0, 1'b1, c); chk("R11 held idle", c, 0);
        low_power = 1'b0; #1;
        count_lvl(P + 3, 0, 1'b1, c); chk("R11 resumed remainder", c, P - 5);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule